// File: doc/BRIEF.md
# Synchronous-Rectifier PWM On-Time Limiter

This block cleans up the gate drive of a synchronous-rectifier switch. A raw PWM waveform enters on one pin, is brought into the block clock domain and searched for rising and falling edges. A set/reset state bit forms the refined output: a rising edge sets it, and a falling edge of the raw input clears it. A counter starts on every rising edge, and if it reaches the programmed limit before the input falls, the state bit is cleared early. The high time of the refined output therefore never exceeds the limit. This keeps reverse current out of the rectifier switch when the converter runs below its resonant frequency.

The limit is given in block clock cycles and is captured on each rising edge, so a new value written during a pulse applies from the next pulse. A limit of zero turns the truncation off, and the output then follows the input edges. Every edge reaches the output a fixed three clock cycles after it appears at the pin.

Top module: `sr_ontime_limiter`

## Requirements
- R1: An input rising edge sets the output high exactly three clock cycles after the new level is first sampled at the pin. No other event sets the output.
- R2: When the input pulse lasts H cycles and H does not exceed a nonzero limit L, the output pulse lasts exactly H cycles.
- R3: When the input pulse lasts longer than a nonzero limit L, the output pulse lasts exactly L cycles and then goes low while the input is still high.
- R4: After truncation the output stays low until the next input rising edge, so each input pulse yields exactly one output pulse.
- R5: A limit of zero disables truncation. The output pulse width then equals the input pulse width for any width.
- R6: The limit is captured on the input rising edge. A change during a pulse does not alter that pulse and applies from the next pulse.
- R7: After reset the output is low. An input that is already high when reset is released produces no output pulse until it has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; counts are in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | Raw rectifier PWM, asynchronous to clk |
| limit | input | CNT_W | Maximum high time in clock cycles, 0 = no limit |
| pwm_out | output | 1 | Refined PWM with bounded high time |

## Verification
On every cycle the in-line assertions check the following. The output rises only one cycle after a detected rising edge, and a detected falling edge drops it on the next cycle. A counter match without a coinciding rising edge drops it on the next cycle, and matches are never back to back. Reset leaves the output low. The exact pulse widths need the bench's swept scenarios. The min(H, L) law over many widths and limits, the three-cycle latency, the deferred effect of a limit change during a pulse, and the absence of a pulse after reset with the input already high can only be shown this way.

// File: rtl/sr_ontime_limiter.sv
module sr_ontime_limiter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic [CNT_W-1:0] limit,
  output logic             pwm_out
);

  logic             s1, s2, lvl_d;
  logic             running;
  logic [CNT_W-1:0] cnt, lim_q;
  logic             rise, fall, match, clr;

  assign rise  = s2 & ~lvl_d;
  assign fall  = ~s2 & lvl_d;
  assign match = running && (lim_q != '0) && (cnt == lim_q);
  assign clr   = fall | match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1    <= pwm_in;
      s2    <= pwm_in;
      lvl_d <= pwm_in;
    end else begin
      s1    <= pwm_in;
      s2    <= s1;
      lvl_d <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      lim_q   <= '0;
    end else if (rise) begin
      running <= (limit != '0);
      cnt     <= CNT_W'(1);
      lim_q   <= limit;
    end else if (clr) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pwm_out <= 1'b0;
    else if (rise) pwm_out <= 1'b1;
    else if (clr)  pwm_out <= 1'b0;
  end

  a_r1_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> pwm_out);
  a_r1_no_other_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(rise));
  a_r2_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !pwm_out);
  a_r3_match_truncates: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !rise) |=> !pwm_out);
  a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match);
  a_r7_reset_low: assert property (@(posedge clk)
    $rose(rst_n) |-> !pwm_out);

endmodule

// File: tb/tb_sr_ontime_limiter.sv
`timescale 1ns/1ps
module tb_sr_ontime_limiter;
  localparam int CNT_W = 8;
  localparam int WIN   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0;
  logic [CNT_W-1:0] limit = '0;
  logic pwm_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sr_ontime_limiter #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .limit(limit), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one pulse of h cycles with limit l (changed to l2 at sample 5).
  task automatic pulse(input int h, input int l, input int l2,
                       output int width, output int first, output int rises);
    int prev;
    prev = 0; width = 0; first = -1; rises = 0;
    @(negedge clk);
    limit = CNT_W'(l);
    pwm_in = 1'b1;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      if (k == h) pwm_in = 1'b0;
      if (k == 5) limit = CNT_W'(l2);
      if (pwm_out) begin
        width++;
        if (first < 0) first = k;
        if (!prev) rises++;
      end
      prev = int'(pwm_out);
    end
  endtask

  initial begin
    int w, f, r, expw;
    // R7: input high during and after reset
    pwm_in = 1'b1;
    limit = 8'd4;
    repeat (4) @(negedge clk);
    check("R7 reset output", int'(pwm_out), 0);
    rst_n = 1'b1;
    w = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      w += int'(pwm_out);
    end
    check("R7 no pulse on high input after reset", w, 0);
    pwm_in = 1'b0;
    repeat (5) @(negedge clk);

    // R1..R5 sweep
    for (int l = 0; l <= 10; l++) begin
      for (int h = 1; h <= 14; h++) begin
        pulse(h, l, l, w, f, r);
        expw = (l == 0 || h <= l) ? h : l;
        if (l == 0)      check($sformatf("R5 width h=%0d", h), w, expw);
        else if (h <= l) check($sformatf("R2 width h=%0d l=%0d", h, l), w, expw);
        else             check($sformatf("R3 width h=%0d l=%0d", h, l), w, expw);
        check($sformatf("R1 latency h=%0d l=%0d", h, l), f, 3);
        check($sformatf("R4 one pulse h=%0d l=%0d", h, l), r, 1);
      end
    end

    // R5 long pulse with no limit
    pulse(30, 0, 0, w, f, r);
    check("R5 long pulse unlimited", w, 30);

    // R6: limit raised mid-pulse, then applies next pulse
    pulse(20, 5, 10, w, f, r);
    check("R6 mid-pulse change ignored", w, 5);
    pulse(20, 10, 10, w, f, r);
    check("R6 new limit on next pulse", w, 10);
    pulse(20, 9, 2, w, f, r);
    check("R6 lowered mid-pulse ignored", w, 9);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule